// File: doc/BRIEF.md
# Frame-Aligned Elastic Store

This block decouples a byte stream of 32-byte frames arriving on a write clock from a reader running on its own clock. Two whole frames of storage sit between the sides. When the clocks drift far enough that one side would overtake the other, the store slips by a complete frame. Too much incoming data throws away one entire incoming frame. Too little data sends out the previous frame a second time. The reader never sees a partial frame, and byte 0 of every frame stays marked.

Each slip is recorded in a sticky status byte on a small register port in the read clock domain. A read of that byte clears it, and a write of ones clears the chosen bits. An enable byte masks the status bits onto a level interrupt. The writer marks byte 0 of each frame with `wr_sof`. The reader receives the same marking on `rd_sof`. The first frame read after reset is the unwritten half of the store, and the writer's first frame follows it.

Top module: `frame_slip_buffer`

## Requirements
- R1: During and after reset, `rd_data` and `rd_sof` are 0, `irq` is 0, and both the status byte (`reg_addr`=0) and the enable byte (`reg_addr`=1) read 0.
- R2: When the two sides run at equal rates, every frame after the first appears whole and in order on the read side. `rd_sof` is 1 exactly on byte 0. The byte for a read accepted at a `rclk` edge is present after that edge.
- R3: A writer that starts a frame while two frames are still unread loses that whole incoming frame. None of its bytes are ever read, and later frames stay whole.
- R4: A reader that starts a frame while no byte of the next frame has been written receives the previous frame again, whole, and no frame is lost.
- R5: A frame deletion sets status bit 7 (full) and bit 5 (slip).
- R6: A frame repetition sets status bit 6 (empty) and bit 5 (slip).
- R7: Status bits 4..0 always read 0. The enable byte keeps bits 7..5 of a write to `reg_addr`=1, and its bits 4..0 read 0.
- R8: A status read (`reg_rd` with `reg_addr`=0) clears every status bit at that `rclk` edge. An event in the same cycle leaves its bit set.
- R9: Writing to `reg_addr`=0 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R10: `irq` is 1 exactly while some status bit and its enable bit are both 1, so it stays high until software clears the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side and register clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe for one byte |
| wr_sof | input | 1 | Marks the written byte as byte 0 of a frame |
| wr_data | input | 8 | Byte written |
| rd_en | input | 1 | Read strobe for one byte |
| rd_data | output | 8 | Byte read, registered |
| rd_sof | output | 1 | Marks `rd_data` as byte 0 of a frame |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_rd | input | 1 | Register read strobe (clears status when `reg_addr`=0) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | Level interrupt |

## Verification
A pointer that slips off a frame boundary shows up at once on the read port. The byte offsets inside the next frame come out of sequence, or `rd_sof` lands on the wrong byte, within 32 reads. A pointer rewound by the wrong amount, or a missed slip decision, shows up as a frame sequence number that repeats or jumps where it should not, by the next frame boundary. A wrongly held or cleared status bit shows up on `irq` in the cycle after the register access, and on the following status read.

// File: rtl/frame_slip_buffer.sv
`timescale 1ns/1ps
module frame_slip_buffer #(
  parameter int DW = 8,
  parameter int FRAME_BYTES = 32
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sof,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_sof,
  input  logic          reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int DEPTH = 2 * FRAME_BYTES;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int OW = $clog2(FRAME_BYTES);
  localparam logic [PW-1:0] FB_P = PW'(FRAME_BYTES);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] FB_GRAY = FB_P ^ (FB_P >> 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wgray, rg1, rg2, rgray;
  logic wdrop, del_tgl;
  wire [PW-1:0] occ_w  = wptr - g2b(rg2);
  wire          w_full = occ_w >= DEPTH_P;
  wire          w_del  = wr_en && wr_sof && w_full;
  wire          w_keep = wr_en && (wr_sof ? !w_full : !wdrop);
  wire [PW-1:0] wnext  = wptr + 1'b1;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wptr <= FB_P;
      wgray <= FB_GRAY;
      rg1 <= '0;
      rg2 <= '0;
      wdrop <= 1'b0;
      del_tgl <= 1'b0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_en && wr_sof) wdrop <= w_full;
      if (w_keep) begin
        wptr <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
      if (w_del) del_tgl <= ~del_tgl;
    end

  always_ff @(posedge wclk)
    if (w_keep) mem[wptr[AW-1:0]] <= wr_data;

  // read domain
  logic [PW-1:0] rptr, wg1, wg2;
  logic [2:0] dsync;
  wire [PW-1:0] occ_r = g2b(wg2) - rptr;
  wire          r_sof = rptr[OW-1:0] == '0;
  wire          r_rep = rd_en && r_sof && (occ_r == '0 || occ_r > DEPTH_P);
  wire [PW-1:0] raddr = r_rep ? rptr - FB_P : rptr;
  wire [PW-1:0] rnext = raddr + 1'b1;
  wire          d_evt = dsync[2] ^ dsync[1];

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr <= '0;
      rgray <= '0;
      wg1 <= '0;
      wg2 <= '0;
      dsync <= '0;
      rd_data <= '0;
      rd_sof <= 1'b0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      dsync <= {dsync[1:0], del_tgl};
      if (rd_en) begin
        rptr <= rnext;
        rgray <= rnext ^ (rnext >> 1);
        rd_data <= mem[raddr[AW-1:0]];
        rd_sof <= r_sof;
      end
    end

  // register port, status bits {full, empty, slip}
  logic [2:0] sts, ien;
  wire st_rd = reg_rd && !reg_addr;
  wire st_wr = reg_wr && !reg_addr;
  wire [2:0] clr = (st_rd ? 3'b111 : 3'b000) | (st_wr ? reg_wdata[7:5] : 3'b000);
  wire [2:0] set = {d_evt, r_rep, d_evt | r_rep};
  wire unused_wbits = ^reg_wdata[4:0];

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      sts <= '0;
      ien <= '0;
    end else begin
      sts <= (sts & ~clr) | set;
      if (reg_wr && reg_addr) ien <= reg_wdata[7:5];
    end

  assign reg_rdata = {reg_addr ? ien : sts, 5'b0};
  assign irq = |(sts & ien);

  a_r3_drop_holds_wptr: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && !wr_sof && wdrop) |=> $stable(wptr));
  a_r4_repeat_rewinds_frame: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && r_rep) |=> (rptr == $past(rptr) - FB_P + 1'b1));
  a_r5_delete_sets_full: assert property (@(posedge rclk) disable iff (!rst_n)
    d_evt |=> (reg_addr || (reg_rdata[7] && reg_rdata[5])));
  a_r6_repeat_sets_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    r_rep |=> (sts[1] && sts[0]));
  a_r8_read_clears: assert property (@(posedge rclk) disable iff (!rst_n)
    (st_rd && !d_evt && !r_rep) |=> (sts == 3'b000));
  a_r10_irq_low_after_clear: assert property (@(posedge rclk) disable iff (!rst_n)
    (st_rd && !d_evt && !r_rep) |=> !irq);
endmodule

// File: tb/tb_frame_slip_buffer.sv
`timescale 1ns/1ps
module tb_frame_slip_buffer;
  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, wr_sof = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_sof;
  logic reg_addr = 0, reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;

  frame_slip_buffer dut (.*);

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  int checks = 0, fails = 0;
  bit done = 0;
  bit w_run = 0, w_hold = 0, r_run = 0, r_hold = 0;
  int woff = 0, wid = 0, rcnt = 0, nread = 0;
  int last_id = 0, reps = 0, skips = 0;
  bit seen = 0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge wclk) begin
    if (w_run && !(woff == 0 && w_hold)) begin
      wr_en = 1;
      wr_sof = (woff == 0);
      wr_data = {wid[2:0], woff[4:0]};
      woff = (woff + 1) % 32;
      if (woff == 0) wid++;
    end else wr_en = 0;
  end

  always @(negedge rclk) begin
    if (rd_en) begin
      nread++;
      if (nread > 32) begin
        int pos, id;
        pos = (nread - 33) % 32;
        id = int'(rd_data[7:5]);
        chk(rd_data[4:0] == pos[4:0] && rd_sof == (pos == 0), "R2 byte offset/sof",
            {rd_sof, rd_data}, {pos == 0, 3'b0, pos[4:0]});
        if (pos == 0) begin
          if (!seen) begin
            chk(id == 0, "R2 first frame", id, 0);
            seen = 1;
          end else begin
            int j;
            j = (id - last_id + 8) % 8;
            if (j == 0) reps++;
            else if (j != 1) skips++;
          end
          last_id = id;
        end else chk(id == last_id, "R3/R4 frame whole", id, last_id);
      end
    end
    if (r_run && !(rcnt % 32 == 0 && r_hold)) begin
      rd_en = 1;
      rcnt++;
    end else rd_en = 0;
  end

  task automatic reg_read(input bit a, output logic [7:0] v);
    @(negedge rclk);
    reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge rclk);
    reg_rd = 0;
  endtask

  task automatic reg_write(input bit a, input logic [7:0] d);
    @(negedge rclk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge rclk);
    reg_wr = 0;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  initial begin
    logic [7:0] v;
    int skips0;
    #30;
    chk(rd_data == 0 && rd_sof == 0, "R1 read port in reset", {rd_sof, rd_data}, 0);
    chk(irq == 0, "R1 irq in reset", irq, 0);
    #22 rst_n = 1;
    reg_read(0, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    reg_read(1, v); chk(v == 8'h00, "R1 enable after reset", v, 0);
    reg_write(1, 8'hFF);
    reg_read(1, v); chk(v == 8'hE0, "R7 enable keeps bits 7..5", v, 8'hE0);

    w_run = 1;
    repeat (16) @(negedge wclk);
    r_run = 1;
    wait_r(800);
    chk(skips == 0 && reps == 0, "R2 steady order", skips * 256 + reps, 0);
    chk(irq == 0, "R10 no slip no irq", irq, 0);
    reg_read(0, v); chk(v == 8'h00, "R2 no slip at equal rates", v, 0);

    r_hold = 1; wait_r(120); r_hold = 0;
    wait_r(400);
    chk(skips >= 1 && reps == 0, "R3 frame deleted", skips * 256 + reps, 256);
    chk(irq == 1, "R10 irq on deletion", irq, 1);
    reg_read(0, v); chk(v == 8'hA0, "R5 full+slip, R7 low bits 0", v, 8'hA0);
    reg_read(0, v); chk(v == 8'h00, "R8 read cleared status", v, 0);
    chk(irq == 0, "R10 irq cleared", irq, 0);
    skips0 = skips;

    w_hold = 1; wait_r(150); w_hold = 0;
    wait_r(400);
    chk(reps >= 1, "R4 frame repeated", reps, 1);
    chk(skips == skips0, "R4 no frame lost", skips, skips0);
    reg_write(0, 8'h1F);
    reg_write(0, 8'h20);
    reg_write(1, 8'h20);
    #1 chk(irq == 0, "R9 slip cleared by write", irq, 0);
    reg_write(1, 8'h40);
    #1 chk(irq == 1, "R10 empty enabled", irq, 1);
    reg_write(1, 8'h80);
    #1 chk(irq == 0, "R10 full masked", irq, 0);
    reg_read(0, v); chk(v == 8'h40, "R6 empty set, R9 others kept", v, 8'h40);
    reg_read(0, v); chk(v == 8'h00, "R8 read cleared status", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule